// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath of a 32-bit processor that runs each instruction over several clock cycles. One ALU and one word-addressed memory, which holds both code and data, are shared between the steps of an instruction; holding registers keep the values passed between steps: the instruction register, the data register, the two operand registers and the ALU output register. An external sequencer drives every write enable and every multiplexer select on each cycle. The datapath returns the fields that the sequencer decodes and a flag that is high when the ALU result is zero.

The supported instruction subset is load word, store word, register-register arithmetic and logic, add immediate, branch on equal and jump. The ALU also produces the incremented program counter during fetch and the branch target during decode. A preload port lets a test environment write memory words before or between runs. A peek port reads any memory word combinationally.

Top module: `mcd_datapath`

## Requirements
- R1: While rst_n is low at a rising clock edge, the program counter, the instruction register, all holding registers and all register-file entries become zero. Memory contents are not changed by reset.
- R2: The memory byte address is the program counter when addr_sel=0 and the ALU output register when addr_sel=1. The word index is address bits [7:2]. When mem_wr=1, the word at that index is written with the operand-B register at the clock edge. Reads are combinational.
- R3: The instruction register loads the memory read word only on an edge where ir_wr=1. opcode is bits [31:26] of the instruction register and funct is bits [5:0].
- R4: The data register captures the memory read word on every clock edge. When wb_sel=1, the register-file write data is the data register; when wb_sel=0, it is the ALU output register.
- R5: ALU operand B is selected by opb_sel: 00 gives the B register, 01 gives the constant 4, 10 gives the sign-extended instr[15:0], and 11 gives that value shifted left by two.
- R6: ALU operand A is the program counter when opa_sel=0 and the A register when opa_sel=1.
- R7: alu_ctl selects the ALU function: 010 add, 110 subtract, 000 AND, 001 OR, 111 signed set-less-than (result 1 or 0). Any other code gives 0. zero is 1 exactly when the current ALU result is 0.
- R8: The program counter loads on an edge only when pc_wr=1, or when br_en=1 and zero=1. Otherwise it holds.
- R9: The next program counter is selected by npc_sel: 00 or 11 gives the live ALU result, 01 gives the ALU output register, and 10 gives {pc[31:28], instr[25:0], 2'b00}.
- R10: The register-file write address is instr[20:16] when dst_sel=0 and instr[15:11] when dst_sel=1. The write occurs at the clock edge when rf_wr=1.
- R11: Register 0 always reads as zero. Writes to register 0 are discarded.
- R12: On every edge, the A register loads register instr[25:21], the B register loads register instr[20:16], and the ALU output register loads the live ALU result. There is no enable on these registers.
- R13: When pre_we=1, memory word pre_addr is written with pre_data at the edge. If mem_wr is also 1 in that cycle, the preload wins and the datapath store is dropped. peek_data shows memory word peek_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_wr | input | 1 | Unconditional program counter load |
| br_en | input | 1 | Program counter load when zero is high |
| addr_sel | input | 1 | Memory address select: 0 PC, 1 ALU output register |
| ir_wr | input | 1 | Instruction register load |
| mem_wr | input | 1 | Memory store from the B register |
| rf_wr | input | 1 | Register-file write |
| dst_sel | input | 1 | Write address: 0 instr[20:16], 1 instr[15:11] |
| wb_sel | input | 1 | Write data: 0 ALU output register, 1 data register |
| opa_sel | input | 1 | ALU operand A: 0 PC, 1 A register |
| opb_sel | input | 2 | ALU operand B select |
| alu_ctl | input | 3 | ALU function code |
| npc_sel | input | 2 | Next program counter select |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 6 | Preload word index |
| pre_data | input | 32 | Preload word |
| peek_addr | input | 6 | Peek word index |
| opcode | output | 6 | Instruction register bits [31:26] |
| funct | output | 6 | Instruction register bits [5:0] |
| zero | output | 1 | Live ALU result is zero |
| pc | output | 32 | Program counter |
| peek_data | output | 32 | Memory word at peek_addr |

## Verification
The hardest case to reach is a conditional program counter load. The load depends on a zero flag produced in the same cycle from operand registers that were filled two edges earlier, from register values that were themselves written by earlier instructions. The stimulus therefore runs a real instruction sequence through sequencer-like control steps, so that operands build up naturally. It then takes a branch between equal registers and declines one between unequal registers, and checks that the target computed during decode is only used in the taken case. Writes aimed at register 0 are followed by an instruction that reads it back, and a preload that collides with a store is set up by first steering the ALU output register onto the same word.

// File: rtl/mcd_pkg.sv
// Shared constants and types for the multicycle datapath.
// Assumes a 32-bit word and the fixed instruction field layout.
package mcd_pkg;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    localparam int REG_AW = 5;
    localparam int OP_W   = 6;

endpackage

// File: rtl/mcd_alu.sv
// Combinational ALU with a zero flag.
// Assumes a two's complement operand; codes outside the enum produce 0.
module mcd_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [2:0]   fn,
    output logic [W-1:0] res,
    output logic         is_zero
);
    import mcd_pkg::*;

    // Select the ALU function.
    always_comb begin
        case (fn)
            ALU_AND: res = src_a & src_b;
            ALU_OR:  res = src_a | src_b;
            ALU_ADD: res = src_a + src_b;
            ALU_SUB: res = src_a - src_b;
            ALU_SLT: res = {{(W-1){1'b0}}, ($signed(src_a) < $signed(src_b))};
            default: res = '0;
        endcase
    end

    assign is_zero = (res == '0);
endmodule

// File: rtl/mcd_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 reads as zero and is never written. Reads return the value
// held before a same-edge write, with no bypass.
module mcd_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs [N];

    // Clear on reset; otherwise write any entry other than 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // Force entry 0 to read as zero on both ports.
    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mcd_mem.sv
// Word memory shared by instruction and data accesses.
// It has a combinational read, a synchronous write, a preload port that takes
// priority over the datapath store, and a combinational peek port.
// There is no reset.
module mcd_mem #(
    parameter int W = 32,
    parameter int WORDS = 64,
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd,
    input  logic          pre_we,
    input  logic [IW-1:0] pre_idx,
    input  logic [W-1:0]  pre_wd,
    input  logic [IW-1:0] peek_idx,
    output logic [W-1:0]  peek_rd
);
    logic [W-1:0] words [WORDS];

    // Write a preload word first; otherwise do the datapath store.
    always_ff @(posedge clk) begin
        if (pre_we)  words[pre_idx] <= pre_wd;
        else if (we) words[idx] <= wd;
    end

    assign rd      = words[idx];
    assign peek_rd = words[peek_idx];
endmodule

// File: rtl/mcd_datapath.sv
// Datapath of a multicycle processor. One ALU and one memory are
// time-shared under external control through holding registers.
// Assumes the sequencer drives every enable and select on each cycle.
module mcd_datapath #(
    parameter int XLEN = 32,
    parameter int MEM_WORDS = 64,
    localparam int IW = $clog2(MEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_wr,
    input  logic            br_en,
    input  logic            addr_sel,
    input  logic            ir_wr,
    input  logic            mem_wr,
    input  logic            rf_wr,
    input  logic            dst_sel,
    input  logic            wb_sel,
    input  logic            opa_sel,
    input  logic [1:0]      opb_sel,
    input  logic [2:0]      alu_ctl,
    input  logic [1:0]      npc_sel,
    input  logic            pre_we,
    input  logic [IW-1:0]   pre_addr,
    input  logic [XLEN-1:0] pre_data,
    input  logic [IW-1:0]   peek_addr,
    output logic [5:0]      opcode,
    output logic [5:0]      funct,
    output logic            zero,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] peek_data
);
    import mcd_pkg::*;

    logic [XLEN-1:0] pc_q, ir_q, dr_q, a_q, b_q, alu_q;
    logic [XLEN-1:0] mem_byte_addr, mem_rd, rf_rd1, rf_rd2, rf_wd;
    logic [XLEN-1:0] imm_ext, src_a, src_b, alu_y, npc;
    logic [REG_AW-1:0] rf_wa;
    logic pc_en;
    logic unused_bits;

    assign mem_byte_addr = addr_sel ? alu_q : pc_q;
    assign unused_bits   = ^{ir_q[10:6], mem_byte_addr[XLEN-1:IW+2], mem_byte_addr[1:0]};

    mcd_mem #(.W(XLEN), .WORDS(MEM_WORDS)) u_mem (
        .clk(clk), .we(mem_wr), .idx(mem_byte_addr[IW+1:2]), .wd(b_q), .rd(mem_rd),
        .pre_we(pre_we), .pre_idx(pre_addr), .pre_wd(pre_data),
        .peek_idx(peek_addr), .peek_rd(peek_data)
    );

    assign rf_wa = dst_sel ? ir_q[15:11] : ir_q[20:16];
    assign rf_wd = wb_sel ? dr_q : alu_q;

    mcd_regfile #(.W(XLEN), .N(1 << REG_AW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_wr), .wa(rf_wa), .wd(rf_wd),
        .ra1(ir_q[25:21]), .ra2(ir_q[20:16]), .rd1(rf_rd1), .rd2(rf_rd2)
    );

    assign imm_ext = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
    assign src_a   = opa_sel ? a_q : pc_q;

    // Pick ALU operand B.
    always_comb begin
        case (opb_sel)
            2'b00:   src_b = b_q;
            2'b01:   src_b = XLEN'(4);
            2'b10:   src_b = imm_ext;
            default: src_b = {imm_ext[XLEN-3:0], 2'b00};
        endcase
    end

    mcd_alu #(.W(XLEN)) u_alu (
        .src_a(src_a), .src_b(src_b), .fn(alu_ctl), .res(alu_y), .is_zero(zero)
    );

    // Pick the next program counter.
    always_comb begin
        case (npc_sel)
            2'b01:   npc = alu_q;
            2'b10:   npc = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
            default: npc = alu_y;
        endcase
    end

    assign pc_en = pc_wr | (br_en & zero);

    // Program counter with a conditional load.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_en) pc_q <= npc;
    end

    // Instruction register, loaded only on fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ir_wr) ir_q <= mem_rd;
    end

    // Holding registers loaded on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            alu_q <= '0;
        end else begin
            dr_q  <= mem_rd;
            a_q   <= rf_rd1;
            b_q   <= rf_rd2;
            alu_q <= alu_y;
        end
    end

    assign opcode = ir_q[31:26];
    assign funct  = ir_q[5:0];
    assign pc     = pc_q;
endmodule

// File: rtl/mcd_datapath_chk.sv
// Assertion checker for mcd_datapath, attached by bind.
// Assumes a synchronous active-low reset.
module mcd_datapath_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pc_wr,
    input logic            br_en,
    input logic            ir_wr,
    input logic            zero,
    input logic [1:0]      npc_sel,
    input logic [XLEN-1:0] pc,
    input logic [5:0]      opcode,
    input logic [5:0]      funct,
    input logic [XLEN-1:0] ir_q,
    input logic [XLEN-1:0] a_q
);
    // R1
    pc_after_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> pc == '0);

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_wr || (br_en && zero)) |=> $stable(pc));

    // R3
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> $stable({opcode, funct}));

    // R11
    reg_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[25:21] == 5'd0) |=> a_q == '0);

    // R9
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && npc_sel == 2'b10) |=>
        pc == {$past(pc[XLEN-1:XLEN-4]), $past(ir_q[25:0]), 2'b00});
endmodule

bind mcd_datapath mcd_datapath_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .br_en(br_en), .ir_wr(ir_wr),
    .zero(zero), .npc_sel(npc_sel), .pc(pc), .opcode(opcode), .funct(funct),
    .ir_q(ir_q), .a_q(a_q)
);

// File: tb/tb_mcd_datapath.sv
`timescale 1ns/1ps
module tb_mcd_datapath;
    logic clk = 0;
    logic rst_n = 0;
    logic c_pcw, c_br, c_as, c_irw, c_mw, c_rfw, c_dst, c_wb, c_opa, c_pre;
    logic [1:0] c_opb, c_npc;
    logic [2:0] c_alu;
    logic [5:0] c_pre_a, c_peek;
    logic [31:0] c_pre_d;
    logic [5:0] opcode, funct;
    logic zero;
    logic [31:0] pc, peek_data;

    int nchk = 0, nerr = 0;
    bit done = 0;

    // Behavioural reference state.
    logic [31:0] pc_m, ir_m, dr_m, a_m, b_m, ao_m;
    logic [31:0] rf_m [32];
    logic [31:0] mem_m [64];

    always #4 clk = ~clk;

    mcd_datapath dut (
        .clk(clk), .rst_n(rst_n), .pc_wr(c_pcw), .br_en(c_br), .addr_sel(c_as),
        .ir_wr(c_irw), .mem_wr(c_mw), .rf_wr(c_rfw), .dst_sel(c_dst), .wb_sel(c_wb),
        .opa_sel(c_opa), .opb_sel(c_opb), .alu_ctl(c_alu), .npc_sel(c_npc),
        .pre_we(c_pre), .pre_addr(c_pre_a), .pre_data(c_pre_d), .peek_addr(c_peek),
        .opcode(opcode), .funct(funct), .zero(zero), .pc(pc), .peek_data(peek_data)
    );

    function automatic logic [31:0] alu_m(logic [31:0] x, logic [31:0] y, logic [2:0] f);
        case (f)
            3'b010: return x + y;
            3'b110: return x - y;
            3'b000: return x & y;
            3'b001: return x | y;
            3'b111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] res_m();
        logic [31:0] sa, sb, imm;
        imm = {{16{ir_m[15]}}, ir_m[15:0]};
        sa = c_opa ? a_m : pc_m;
        case (c_opb)
            2'b00: sb = b_m;
            2'b01: sb = 32'd4;
            2'b10: sb = imm;
            default: sb = imm << 2;
        endcase
        return alu_m(sa, sb, c_alu);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Advance the model by one edge using the pre-edge state.
    task automatic model_edge();
        logic [31:0] r, rd, addr, npc, wd;
        logic [4:0] wa;
        r = res_m();
        addr = c_as ? ao_m : pc_m;
        rd = mem_m[addr[7:2]];
        case (c_npc)
            2'b01: npc = ao_m;
            2'b10: npc = {pc_m[31:28], ir_m[25:0], 2'b00};
            default: npc = r;
        endcase
        wa = c_dst ? ir_m[15:11] : ir_m[20:16];
        wd = c_wb ? dr_m : ao_m;
        if (c_pre) mem_m[c_pre_a] = c_pre_d;
        else if (c_mw) mem_m[addr[7:2]] = b_m;
        if (!rst_n) begin
            pc_m = 0; ir_m = 0; dr_m = 0; a_m = 0; b_m = 0; ao_m = 0;
            for (int i = 0; i < 32; i++) rf_m[i] = 0;
        end else begin
            if (c_pcw || (c_br && r == 0)) pc_m = npc;
            if (c_irw) ir_m = rd;
            dr_m = rd;
            a_m = rf_m[ir_m[25:21]];
            b_m = rf_m[ir_m[20:16]];
            ao_m = r;
            if (c_rfw && wa != 0) rf_m[wa] = wd;
        end
    endtask

    // Compare all outputs mid-cycle, then take one edge.
    task automatic tick(string tag);
        #1;
        chk(tag, "pc", pc, pc_m);
        chk(tag, "opcode", {26'd0, opcode}, {26'd0, ir_m[31:26]});
        chk(tag, "funct", {26'd0, funct}, {26'd0, ir_m[5:0]});
        chk(tag, "zero", {31'd0, zero}, {31'd0, (res_m() == 0)});
        chk(tag, "peek", peek_data, mem_m[c_peek]);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle();
    endtask

    task automatic idle();
        c_pcw = 0; c_br = 0; c_as = 0; c_irw = 0; c_mw = 0; c_rfw = 0;
        c_dst = 0; c_wb = 0; c_opa = 0; c_opb = 0; c_alu = 3'b010; c_npc = 0;
        c_pre = 0; c_pre_a = 0; c_pre_d = 0;
    endtask

    task automatic fetch_dec();
        c_irw = 1; c_pcw = 1; c_opb = 2'b01; tick("R2 R3 R5 R6 R9");
        c_opb = 2'b11; tick("R5 R12 decode target");
    endtask

    task automatic do_lw();
        fetch_dec();
        c_opa = 1; c_opb = 2'b10; tick("R5 R6 R7");
        c_as = 1; tick("R2 R4");
        c_wb = 1; c_rfw = 1; tick("R4 R10");
    endtask

    task automatic do_sw();
        fetch_dec();
        c_opa = 1; c_opb = 2'b10; tick("R5");
        c_as = 1; c_mw = 1; tick("R2 store");
    endtask

    task automatic do_r(logic [2:0] f);
        fetch_dec();
        c_opa = 1; c_alu = f; tick("R7 R12");
        c_dst = 1; c_rfw = 1; tick("R10 R11");
    endtask

    task automatic do_addi();
        fetch_dec();
        c_opa = 1; c_opb = 2'b10; tick("R5 sign");
        c_rfw = 1; tick("R10 R11");
    endtask

    task automatic do_beq();
        fetch_dec();
        c_opa = 1; c_alu = 3'b110; c_npc = 2'b01; c_br = 1; tick("R8 R9 branch");
    endtask

    task automatic do_j();
        fetch_dec();
        c_npc = 2'b10; c_pcw = 1; tick("R9 jump");
    endtask

    function automatic logic [31:0] rt(int rs, int t, int d, int fn);
        return {6'd0, 5'(rs), 5'(t), 5'(d), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] it(int op, int rs, int t, int imm);
        return {6'(op), 5'(rs), 5'(t), 16'(imm)};
    endfunction

    task automatic preload(int a, logic [31:0] d);
        c_pre = 1; c_pre_a = 6'(a); c_pre_d = d; tick("R13 preload");
    endtask

    initial begin
        #(8 * 100000);
        nerr++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        idle();
        c_peek = 6'd58;
        pc_m = 0; ir_m = 0; dr_m = 0; a_m = 0; b_m = 0; ao_m = 0;
        for (int i = 0; i < 32; i++) rf_m[i] = 0;
        for (int i = 0; i < 64; i++) mem_m[i] = 0;
        @(negedge clk);
        // R13 preload the memory while reset is held, then R1 reset state.
        for (int i = 0; i < 64; i++) preload(i, 32'd0);
        preload(0,  it(35, 0, 1, 'hE0));
        preload(1,  it(35, 0, 2, 'hE4));
        preload(2,  rt(1, 2, 3, 'h20));
        preload(3,  rt(1, 1, 4, 'h22));
        preload(4,  it(43, 0, 3, 'hE8));
        preload(5,  it(4, 1, 1, 1));
        preload(6,  it(8, 0, 9, 1));
        preload(7,  it(8, 1, 0, 5));
        preload(8,  rt(0, 2, 6, 'h25));
        preload(9,  rt(2, 1, 7, 'h2A));
        preload(10, rt(1, 2, 8, 'h24));
        preload(11, it(4, 1, 2, 3));
        preload(12, it(8, 2, 10, -8));
        preload(13, {6'd2, 26'd0});
        preload(56, 32'd7);
        preload(57, 32'hFFFF_FFFD);
        tick("R1 reset");
        rst_n = 1;
        tick("R1 reset state");
        do_lw();                 // r1 = 7
        do_lw();                 // r2 = -3
        do_r(3'b010);            // r3 = 4
        do_r(3'b110);            // r4 = 0, zero seen in execute
        do_sw();                 // R2 store r3 at word 58
        do_beq();                // taken, R8
        do_addi();               // R11 write to r0 dropped
        do_r(3'b001);            // r6 = r0 | r2
        do_r(3'b111);            // r7 = slt
        do_r(3'b000);            // r8 = and
        do_beq();                // not taken, R8
        do_addi();               // r10 = -11
        do_j();                  // R9 back to 0
        // R13 preload wins over a same-cycle store to the same word.
        c_peek = 6'd56;
        fetch_dec();
        c_opa = 1; c_opb = 2'b10; tick("R13 address");
        c_as = 1; c_mw = 1; c_pre = 1; c_pre_a = 6'd56; c_pre_d = 32'h5A5A_0001;
        tick("R13 priority");
        tick("R13 result");
        // R3 a memory read with ir_wr low leaves the instruction register alone.
        c_as = 0; tick("R3 hold");
        c_pcw = 1; c_opb = 2'b01; tick("R3 hold, R8 load");
        // R1 reset in mid-run.
        rst_n = 0; tick("R1 mid-run");
        rst_n = 1; tick("R1 after");
        c_peek = 6'd58; tick("R2 stored word");
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule